// File: doc/BRIEF.md
# Security monitor state controller

This block decides how far a crypto subsystem may be trusted. After reset it walks through a start state and a RAM-clearing phase. It then waits in a health-check state until software checks in. From there it settles in a secure state, which uses the per-device secret key, or a non-secure state, which uses the default key. It moves to a locked fail state on a software alarm or a fatal error.

Detector sources, the RAM zeroizer and the cipher engine lie outside the block. They reach it only as pulse inputs (`err_i`, `checkin_i`) and a done handshake (`zero_done_i`). Software sees the block through two 32-bit registers. The status register holds the encoded state and the sticky error flags. The command register carries the alarm, interrupt enable, interrupt clear and bit-bank clear.

The parameter `FATAL_MASK` sets which error sources are fatal. By default these are sources 1, 3 and 5.

Top module: `secmon_ctrl`

## Requirements
- R1: While reset is held, and before the first clock after it is released, the state field (status bits 4:0) reads 0x00. In that same window the status word is zero, and `irq_o`, `key_sel_o`, `cipher_en_o` and `zero_req_o` are all low.
- R2: The start state moves to the RAM-clear state (code 0x05) on the next clock. `zero_req_o` is high only in the RAM-clear state. That state moves to health-check (code 0x06) on the first clock at which `zero_done_i` is high.
- R3: A `checkin_i` pulse in health-check with no non-fatal error pending moves the block to secure (code 0x0A). In secure, `key_sel_o` and `cipher_en_o` are both 1. A `checkin_i` pulse in any other state is ignored.
- R4: A non-fatal error that is pending at check-in moves health-check to non-secure (code 0x0C). A non-fatal error that arrives in secure also moves the block to non-secure. In non-secure, `key_sel_o`=0 and `cipher_en_o`=1.
- R5: Writing the command register with bit 0 set enters fail (code 0x09) on that clock, from any state, and sets sticky status bit 13. Only reset leaves fail. In fail, `key_sel_o`=0 and `cipher_en_o`=0.
- R6: An error pulse on a source whose `FATAL_MASK` bit is set moves the block to fail on the next clock. By default the fatal sources are 1, 3 and 5.
- R7: Each `err_i[i]` pulse sets a sticky status flag. Sources 0 to 4 map to status bits 8 to 12. Source 5 maps to status bit 24.
- R8: A command write with bit 3 set clears every sticky flag, except in fail, where the flags are kept. A flag whose source pulses in the same cycle as the clear stays set.
- R9: A command write with bit 2 set raises `bb_clear_o` for exactly the following cycle. Outside fail, the same write also clears the bit-bank flag (status bit 10) and no other flag.
- R10: Each command write loads the interrupt enable from bit 1. Reading the command register returns the enable in bit 1 and zero in every other bit. `irq_o` is high exactly when the enable is set and at least one sticky flag is set.
- R11: Writes to the status address (`wr_sel_i`=0) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 command |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 status, 1 command |
| rd_data_o | output | 32 | Read data |
| zero_done_i | input | 1 | RAM zeroizer finished |
| zero_req_o | output | 1 | RAM zeroize request |
| checkin_i | input | 1 | Software check-in pulse |
| err_i | input | 6 | Detector error pulses |
| bb_clear_o | output | 1 | One-cycle bit-bank clear pulse |
| key_sel_o | output | 1 | 1 selects the secret key, 0 the default key |
| cipher_en_o | output | 1 | Cipher side allowed to operate |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest conditions to reach are the collisions.

- A flag clear that lands in the same cycle as a new error pulse.
- A clear command issued while the block is locked in fail.
- A check-in that arrives while a non-fatal flag is still pending from before health-check.

To reach each of these, the bench brings the block up from reset every time. It then drives the write strobe and the error pulse on the same falling edge, so both reach the same rising edge. It also sweeps every error source both from secure and from health-check. The expected state and flag bit for each sweep come from the fatal mask and the bit mapping.

// File: rtl/secmon_pkg.sv
package secmon_pkg;
  localparam int unsigned ST_W      = 5;
  localparam int unsigned N_SRC     = 6;
  localparam int unsigned BB_SRC    = 2;
  localparam int unsigned ALARM_POS = 13;
  localparam int unsigned DATA_W    = 32;

  localparam int unsigned CMD_ALARM   = 0;
  localparam int unsigned CMD_IRQ_EN  = 1;
  localparam int unsigned CMD_BB_CLR  = 2;
  localparam int unsigned CMD_IRQ_CLR = 3;

  typedef enum logic [ST_W-1:0] {
    ST_START  = 5'h00,
    ST_ZERO   = 5'h05,
    ST_HEALTH = 5'h06,
    ST_FAIL   = 5'h09,
    ST_SECURE = 5'h0A,
    ST_NONSEC = 5'h0C
  } mon_state_e;

  // status bit of each detector source
  function automatic int unsigned src_pos(input int unsigned idx);
    return (idx == N_SRC - 1) ? 24 : 8 + idx;
  endfunction
endpackage

// File: rtl/secmon_cmd.sv
module secmon_cmd
  import secmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] data_i,
  output logic       alarm_o,
  output logic       clr_all_o,
  output logic       clr_bb_o,
  output logic       irq_en_o,
  output logic       bb_pulse_o
);
  logic irq_en_q, bb_q;

  assign alarm_o   = wr_i & data_i[CMD_ALARM];
  assign clr_all_o = wr_i & data_i[CMD_IRQ_CLR];
  assign clr_bb_o  = wr_i & data_i[CMD_BB_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      bb_q     <= 1'b0;
    end else begin
      if (wr_i) irq_en_q <= data_i[CMD_IRQ_EN];
      bb_q <= clr_bb_o;
    end
  end

  assign irq_en_o   = irq_en_q;
  assign bb_pulse_o = bb_q;

  p_bb_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_bb_o |=> bb_pulse_o);
endmodule

// File: rtl/secmon_flags.sv
module secmon_flags
  import secmon_pkg::*;
#(
  parameter int unsigned NS = N_SRC,
  parameter int unsigned BB = BB_SRC
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [NS-1:0] src_i,
  input  logic        alarm_i,
  input  logic        clr_all_i,
  input  logic        clr_bb_i,
  input  logic        hold_i,
  output logic [NS:0] flags_o
);
  logic [NS:0] flags_q;
  logic [NS:0] set_v;

  assign set_v = {alarm_i, src_i};

  for (genvar g = 0; g <= NS; g++) begin : g_flag
    localparam bit IS_BB = (g == BB);
    logic clr;
    assign clr = !hold_i && (clr_all_i || (IS_BB && clr_bb_i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[g] <= 1'b0;
      else if (set_v[g])  flags_q[g] <= 1'b1;
      else if (clr)       flags_q[g] <= 1'b0;
    end
  end

  assign flags_o = flags_q;

  p_keep_in_fail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_src_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((flags_q[NS-1:0] & $past(src_i)) == $past(src_i)));
  p_alarm_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> flags_q[NS]);
endmodule

// File: rtl/secmon_fsm.sv
module secmon_fsm
  import secmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alarm_i,
  input  logic       fatal_i,
  input  logic       soft_now_i,
  input  logic       soft_pend_i,
  input  logic       checkin_i,
  input  logic       zero_done_i,
  output mon_state_e state_o
);
  mon_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q != ST_FAIL && (alarm_i || fatal_i)) begin
      st_d = ST_FAIL;
    end else begin
      unique case (st_q)
        ST_START:  st_d = ST_ZERO;
        ST_ZERO:   if (zero_done_i) st_d = ST_HEALTH;
        ST_HEALTH: if (checkin_i)
                     st_d = (soft_now_i || soft_pend_i) ? ST_NONSEC : ST_SECURE;
        ST_SECURE: if (soft_now_i) st_d = ST_NONSEC;
        ST_NONSEC: st_d = ST_NONSEC;
        ST_FAIL:   st_d = ST_FAIL;
        default:   st_d = ST_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_START;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  p_fail_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAIL) |=> (st_q == ST_FAIL));
  p_fatal_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_i |=> (st_q == ST_FAIL));
  p_start_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START) |=> (st_q == ST_ZERO || st_q == ST_FAIL));
  p_soft_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SECURE && soft_now_i && !fatal_i && !alarm_i) |=> (st_q == ST_NONSEC));
endmodule

// File: rtl/secmon_ctrl.sv
module secmon_ctrl
  import secmon_pkg::*;
#(
  parameter logic [N_SRC-1:0] FATAL_MASK = 6'b101010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              zero_done_i,
  output logic              zero_req_o,
  input  logic              checkin_i,
  input  logic [N_SRC-1:0]  err_i,
  output logic              bb_clear_o,
  output logic              key_sel_o,
  output logic              cipher_en_o,
  output logic              irq_o
);
  localparam logic [N_SRC-1:0] SOFT_MASK = ~FATAL_MASK;

  logic       cmd_wr, alarm, clr_all, clr_bb, irq_en;
  logic [N_SRC:0] flags;
  mon_state_e state;
  logic [DATA_W-1:0] sts_word, cmd_word;
  logic unused_wdata;

  assign cmd_wr       = wr_en_i & wr_sel_i;
  assign unused_wdata = ^wr_data_i[DATA_W-1:4];

  secmon_cmd u_cmd (
    .clk_i, .rst_ni,
    .wr_i      (cmd_wr),
    .data_i    (wr_data_i[3:0]),
    .alarm_o   (alarm),
    .clr_all_o (clr_all),
    .clr_bb_o  (clr_bb),
    .irq_en_o  (irq_en),
    .bb_pulse_o(bb_clear_o)
  );

  secmon_flags #(.NS(N_SRC), .BB(BB_SRC)) u_flags (
    .clk_i, .rst_ni,
    .src_i    (err_i),
    .alarm_i  (alarm),
    .clr_all_i(clr_all),
    .clr_bb_i (clr_bb),
    .hold_i   (state == ST_FAIL),
    .flags_o  (flags)
  );

  secmon_fsm u_fsm (
    .clk_i, .rst_ni,
    .alarm_i    (alarm),
    .fatal_i    (|(err_i & FATAL_MASK)),
    .soft_now_i (|(err_i & SOFT_MASK)),
    .soft_pend_i(|(flags[N_SRC-1:0] & SOFT_MASK)),
    .checkin_i,
    .zero_done_i,
    .state_o    (state)
  );

  always_comb begin
    sts_word = '0;
    sts_word[ST_W-1:0] = state;
    for (int i = 0; i < int'(N_SRC); i++) sts_word[src_pos(i)] = flags[i];
    sts_word[ALARM_POS] = flags[N_SRC];
    cmd_word = '0;
    cmd_word[CMD_IRQ_EN] = irq_en;
  end

  assign rd_data_o   = rd_sel_i ? cmd_word : sts_word;
  assign zero_req_o  = (state == ST_ZERO);
  assign key_sel_o   = (state == ST_SECURE);
  assign cipher_en_o = (state == ST_SECURE) || (state == ST_NONSEC);
  assign irq_o       = irq_en & (|flags);

  p_checkin_secure_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HEALTH && checkin_i && flags == '0 && err_i == '0 && !alarm)
      |=> key_sel_o);
  p_fail_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |=> !cipher_en_o);
endmodule

// File: tb/secmon_ctrl_tb.sv
`timescale 1ns/1ps
module secmon_ctrl_tb;
  import secmon_pkg::*;

  localparam logic [5:0] FMASK = 6'b101010;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, zero_done = 0, checkin = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [5:0] err = '0;
  logic zero_req, bb_clear, key_sel, cipher_en, irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  secmon_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .zero_done_i(zero_done), .zero_req_o(zero_req), .checkin_i(checkin),
    .err_i(err), .bb_clear_o(bb_clear), .key_sel_o(key_sel),
    .cipher_en_o(cipher_en), .irq_o(irq)
  );

  function automatic int fpos(int i);
    return (i == 5) ? 24 : 8 + i;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic status(output logic [31:0] v);
    rd_sel = 0; #1; v = rd_data;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0; wr_data = '0;
  endtask

  task automatic pulse_err(logic [5:0] e);
    err = e; tick(); err = '0;
  endtask

  task automatic pulse_checkin();
    checkin = 1; tick(); checkin = 0;
  endtask

  task automatic to_health();
    rst_n = 0; zero_done = 1; tick(); tick();
    rst_n = 1;
    tick(); tick();
  endtask

  task automatic to_secure();
    to_health(); pulse_checkin();
  endtask

  logic [31:0] s;

  initial begin
    // R1 reset
    tick(); tick();
    status(s);
    chk("R1 status in reset", s, 32'h0);
    chk("R1 outputs in reset", {irq, key_sel, cipher_en, zero_req}, 4'b0);
    rst_n = 1; #1;
    status(s);
    chk("R1 state after release", s[4:0], 5'h00);

    // R2 zeroize handshake
    tick(); status(s);
    chk("R2 enter zero", s[4:0], 5'h05);
    chk("R2 zero_req high", zero_req, 1);
    pulse_checkin();
    status(s);
    chk("R3 checkin ignored outside health", s[4:0], 5'h05);
    tick(); tick(); status(s);
    chk("R2 wait for done", s[4:0], 5'h05);
    zero_done = 1; tick(); status(s);
    chk("R2 health", s[4:0], 5'h06);
    chk("R2 zero_req low", zero_req, 0);

    // R3 secure
    pulse_checkin(); status(s);
    chk("R3 secure", s[4:0], 5'h0A);
    chk("R3 key/cipher", {key_sel, cipher_en}, 2'b11);

    // R11 status write ignored
    wr(0, 32'hFFFF_FFFF); status(s);
    chk("R11 status write ignored", s, 32'h0000_000A);

    // R10 readback and reserved bits
    wr(1, 32'hFFFF_FFF2); rd_sel = 1; #1;
    chk("R10 cmd readback", rd_data, 32'h2);
    chk("R10 no irq without flags", irq, 0);

    // Sweep every source from secure: R4 R6 R7 R8 R10
    for (int i = 0; i < 6; i++) begin
      to_secure();
      wr(1, 32'h2);
      pulse_err(6'(1 << i));
      status(s);
      chk($sformatf("R7 flag src%0d", i), s & ~32'h1F, 32'(1) << fpos(i));
      chk($sformatf("R10 irq src%0d", i), irq, 1);
      if (FMASK[i]) begin
        chk($sformatf("R6 fatal src%0d", i), s[4:0], 5'h09);
        chk("R5 fail outputs", {key_sel, cipher_en}, 2'b00);
        wr(1, 32'hA); status(s);
        chk($sformatf("R8 kept in fail src%0d", i), s & ~32'h1F, 32'(1) << fpos(i));
      end else begin
        chk($sformatf("R4 non-secure src%0d", i), s[4:0], 5'h0C);
        chk("R4 key default", {key_sel, cipher_en}, 2'b01);
        wr(1, 32'hA); status(s);
        chk($sformatf("R8 cleared src%0d", i), s, 32'h0000_000C);
        chk("R10 irq after clear", irq, 0);
      end
    end

    // R4 pending non-fatal at check-in
    for (int i = 0; i < 6; i++) begin
      if (!FMASK[i]) begin
        to_health();
        pulse_err(6'(1 << i));
        status(s);
        chk("R4 still health", s[4:0], 5'h06);
        pulse_checkin(); status(s);
        chk($sformatf("R4 pending src%0d", i), s[4:0], 5'h0C);
      end
    end

    // R5 alarm from start, health, secure
    rst_n = 0; tick(); rst_n = 1;
    wr(1, 32'h1); status(s);
    chk("R5 alarm from start", s, 32'h0000_2009);
    to_health(); wr(1, 32'h1); status(s);
    chk("R5 alarm from health", s, 32'h0000_2009);
    to_secure(); wr(1, 32'h1); status(s);
    chk("R5 alarm from secure", s, 32'h0000_2009);
    pulse_checkin(); tick(); status(s);
    chk("R5 fail is locked", s[4:0], 5'h09);
    rst_n = 0; tick(); rst_n = 1; #1; status(s);
    chk("R5 reset leaves fail", s, 32'h0);

    // R9 bit-bank clear
    to_secure();
    pulse_err(6'b000101);
    wr(1, 32'h4); status(s);
    chk("R9 bb pulse", bb_clear, 1);
    chk("R9 only bitbank cleared", s, 32'h0000_010C);
    tick();
    chk("R9 pulse one cycle", bb_clear, 0);

    // R8 set wins over clear
    err = 6'b000001; wr(1, 32'h8); err = '0; status(s);
    chk("R8 set wins", s, 32'h0000_010C);
    // R10 disabled irq with flag set
    chk("R10 irq masked", irq, 0);
    wr(1, 32'h2);
    chk("R10 irq enabled", irq, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule